// File: doc/BRIEF.md
# Effective Address and Next-PC Unit

This unit produces the two address values a 16-bit multi-cycle processor needs on every step: the value offered to the memory address register and the candidate next program counter. It holds the program counter itself. The controller drives the mux selects. The unit sign-extends an offset taken from the instruction word and adds it either to the current PC (which already points past the instruction) or to a base register value read elsewhere. It then routes the sum, or other sources, to the two outputs.

The controller decides when the PC register captures the next-PC value by raising a load enable. Trap dispatch uses a zero-extended 8-bit vector toward the address register. Register jumps and traps return through the bus input. All arithmetic wraps modulo 2^16.

Top module: `ea_pc_unit`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, pc_o equals RESET_PC (default 16'h3000).
- R2: At a rising clock edge with pc_ld_i = 1, pc_o takes the value next_pc_o had before the edge. With pc_ld_i = 0, pc_o holds its value.
- R3: pc_sel_i = 0 gives next_pc_o = pc_o + 1, so 16'hFFFF becomes 16'h0000.
- R4: off_sel_i = 2 adds the sign-extended field ir_i[8:0] (range -256..+255) to the adder base. base_sel_i = 0 makes that base pc_o.
- R5: off_sel_i = 1 adds the sign-extended field ir_i[5:0] (range -32..+31) to the adder base. base_sel_i = 1 makes that base base_i.
- R6: off_sel_i = 0 or 3 adds zero, so the adder result equals the selected base.
- R7: pc_sel_i = 1 gives next_pc_o = adder result.
- R8: pc_sel_i = 2 gives next_pc_o = bus_i (all 16 bits). pc_sel_i = 3 gives next_pc_o = pc_o.
- R9: mar_sel_i = 0 gives mar_o = adder result. mar_sel_i = 1 gives mar_o = {8'h00, ir_i[7:0]}.
- R10: Every sum is taken modulo 2^16, with no carry out or saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 16 | Instruction word |
| base_i | input | 16 | Base register value |
| bus_i | input | 16 | Bus value for register jumps and traps |
| base_sel_i | input | 1 | Adder base: 0 = PC, 1 = base_i |
| off_sel_i | input | 2 | Offset: 0 none, 1 6-bit, 2 9-bit, 3 none |
| pc_sel_i | input | 2 | Next PC: 0 PC+1, 1 adder, 2 bus, 3 hold |
| mar_sel_i | input | 1 | MAR source: 0 adder, 1 trap vector |
| pc_ld_i | input | 1 | PC load enable |
| pc_o | output | 16 | Current PC |
| mar_o | output | 16 | Value for the memory address register |
| next_pc_o | output | 16 | Next PC value |

## Verification
Directed cases drive offsets at both signs and at their extreme values, 0x100 and 0x0FF in the 9-bit field and 0x20 and 0x1F in the 6-bit field. These cases show whether sign extension uses the right bit. Other directed cases place the PC and base near 0x0000 and 0xFFFF, which exposes any wrap or carry error. Every base and source select is tried with a field in the instruction word that the selected path should not use, so a wrong field or a wrong mux leg shows up as a changed output. A stretch of pseudo-random cycles with random load enables then checks the PC register's hold and load behaviour against the model.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    PC_SRC_INC  = 2'd0,
    PC_SRC_ADDR = 2'd1,
    PC_SRC_BUS  = 2'd2,
    PC_SRC_HOLD = 2'd3
  } pc_src_e;

  typedef enum logic {
    MAR_SRC_ADDR = 1'b0,
    MAR_SRC_VEC  = 1'b1
  } mar_src_e;

  typedef enum logic [1:0] {
    OFF_NONE  = 2'd0,
    OFF_SHORT = 2'd1,
    OFF_LONG  = 2'd2,
    OFF_RSVD  = 2'd3
  } off_sel_e;

  typedef enum logic {
    BASE_PC  = 1'b0,
    BASE_REG = 1'b1
  } base_sel_e;
endpackage

// File: rtl/ea_sext.sv
module ea_sext #(
  parameter int IN_W  = 6,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] ext_o
);
  localparam int PAD_W = OUT_W - IN_W;
  assign ext_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
endmodule

// File: rtl/ea_addr_adder.sv
module ea_addr_adder
  import ea_pkg::*;
#(
  parameter int XLEN   = 16,
  parameter int SHORT_W = 6,
  parameter int LONG_W  = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] ir_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] base_i,
  input  base_sel_e       base_sel_i,
  input  off_sel_e        off_sel_i,
  output logic [XLEN-1:0] sum_o
);
  localparam int N_OFF = 2;
  localparam int OFF_WS [N_OFF] = '{SHORT_W, LONG_W};

  logic [XLEN-1:0] off_ext [N_OFF];
  logic [XLEN-1:0] off_val;
  logic [XLEN-1:0] opnd_base;

  for (genvar g = 0; g < N_OFF; g++) begin : g_sext
    ea_sext #(.IN_W(OFF_WS[g]), .OUT_W(XLEN)) u_sext (
      .val_i(ir_i[OFF_WS[g]-1:0]),
      .ext_o(off_ext[g])
    );
  end

  always_comb begin
    unique case (off_sel_i)
      OFF_SHORT: off_val = off_ext[0];
      OFF_LONG:  off_val = off_ext[1];
      default:   off_val = '0;
    endcase
  end

  assign opnd_base = (base_sel_i == BASE_REG) ? base_i : pc_i;
  assign sum_o     = opnd_base + off_val; // wraps modulo 2^XLEN

  assert_zero_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_sel_i == OFF_NONE && base_sel_i == BASE_PC) |-> sum_o == pc_i);

  // positive short offset stays within its reach of the base
  assert_short_reach_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_sel_i == OFF_SHORT && base_sel_i == BASE_REG && !ir_i[SHORT_W-1])
      |-> (XLEN'(sum_o - base_i) < XLEN'(1 << (SHORT_W-1))));
endmodule

// File: rtl/ea_pc_reg.sv
module ea_pc_reg #(
  parameter int          XLEN     = 16,
  parameter logic [15:0] RESET_PC = 16'h3000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_i,
  input  logic [XLEN-1:0] d_i,
  output logic [XLEN-1:0] q_o
);
  logic [XLEN-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pc_q <= XLEN'(RESET_PC);
    else if (ld_i) pc_q <= d_i;
  end

  assign q_o = pc_q;

  assert_pc_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> pc_q == $past(d_i));

  assert_pc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(pc_q));
endmodule

// File: rtl/ea_pc_unit.sv
module ea_pc_unit
  import ea_pkg::*;
#(
  parameter int          XLEN     = 16,
  parameter int          VEC_W    = 8,
  parameter int          SHORT_W  = 6,
  parameter int          LONG_W   = 9,
  parameter logic [15:0] RESET_PC = 16'h3000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] ir_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] bus_i,
  input  logic            base_sel_i,
  input  logic [1:0]      off_sel_i,
  input  logic [1:0]      pc_sel_i,
  input  logic            mar_sel_i,
  input  logic            pc_ld_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] mar_o,
  output logic [XLEN-1:0] next_pc_o
);
  localparam int VEC_PAD = XLEN - VEC_W;

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] addr_sum;
  logic [XLEN-1:0] vec_zext;

  ea_addr_adder #(.XLEN(XLEN), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_adder (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ir_i      (ir_i),
    .pc_i      (pc_q),
    .base_i    (base_i),
    .base_sel_i(base_sel_e'(base_sel_i)),
    .off_sel_i (off_sel_e'(off_sel_i)),
    .sum_o     (addr_sum)
  );

  assign vec_zext = {{VEC_PAD{1'b0}}, ir_i[VEC_W-1:0]};

  always_comb begin
    unique case (pc_src_e'(pc_sel_i))
      PC_SRC_INC:  next_pc_o = pc_q + XLEN'(1);
      PC_SRC_ADDR: next_pc_o = addr_sum;
      PC_SRC_BUS:  next_pc_o = bus_i;
      default:     next_pc_o = pc_q;
    endcase
  end

  assign mar_o = (mar_src_e'(mar_sel_i) == MAR_SRC_VEC) ? vec_zext : addr_sum;

  ea_pc_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (pc_ld_i),
    .d_i   (next_pc_o),
    .q_o   (pc_q)
  );

  assign pc_o = pc_q;

  assert_vec_upper_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mar_sel_i |-> mar_o[XLEN-1:VEC_W] == '0);

  assert_hold_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_sel_i == 2'd3) |=> $stable(pc_o));
endmodule

// File: tb/ea_pc_unit_test.sv
`timescale 1ns/1ps
module ea_pc_unit_test;
  localparam int CYC_LIMIT = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ir = '0, base = '0, bus = '0;
  logic        base_sel = 1'b0, mar_sel = 1'b0, pc_ld = 1'b0;
  logic [1:0]  off_sel = '0, pc_sel = '0;
  logic [15:0] pc_o, mar_o, next_pc_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int pc_m = 16'h3000;

  always #2.5 clk = ~clk;

  ea_pc_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .ir_i(ir), .base_i(base), .bus_i(bus),
    .base_sel_i(base_sel), .off_sel_i(off_sel), .pc_sel_i(pc_sel),
    .mar_sel_i(mar_sel), .pc_ld_i(pc_ld), .pc_o(pc_o), .mar_o(mar_o),
    .next_pc_o(next_pc_o)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int model_sum();
    int b, o;
    b = base_sel ? int'(base) : pc_m;
    case (off_sel)
      2'd1: o = ir[5] ? int'(ir[5:0]) - 64 : int'(ir[5:0]);
      2'd2: o = ir[8] ? int'(ir[8:0]) - 512 : int'(ir[8:0]);
      default: o = 0;
    endcase
    return (b + o) & 16'hFFFF;
  endfunction

  function automatic int model_next();
    case (pc_sel)
      2'd0: return (pc_m + 1) & 16'hFFFF;
      2'd1: return model_sum();
      2'd2: return int'(bus);
      default: return pc_m;
    endcase
  endfunction

  // one clock: check PC, drive, check combinational outputs, advance model
  task automatic step(string req, logic [15:0] i_ir, logic [15:0] i_base,
                      logic [15:0] i_bus, logic bsel, logic [1:0] osel,
                      logic [1:0] psel, logic msel, logic ld);
    int nx;
    @(negedge clk);
    check({req, " pc"}, pc_o, 16'(pc_m));
    ir = i_ir; base = i_base; bus = i_bus; base_sel = bsel; off_sel = osel;
    pc_sel = psel; mar_sel = msel; pc_ld = ld;
    #1;
    nx = model_next();
    check({req, " next_pc"}, next_pc_o, 16'(nx));
    check({req, " mar"}, mar_o, msel ? {8'h00, i_ir[7:0]} : 16'(model_sum()));
    @(posedge clk);
    if (ld) pc_m = nx;
  endtask

  initial begin
    repeat (CYC_LIMIT) @(posedge clk);
    if (!done) begin
      failures++;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    pc_ld = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset pc", pc_o, 16'h3000);
    rst_n = 1'b1;
    pc_ld = 1'b0;
    // R1 first cycle after reset
    step("R1", 16'h0000, 16'h0, 16'h0, 0, 2'd0, 2'd0, 0, 0);
    // R3 increment and load (R2)
    step("R3", 16'hFFFF, 16'h0, 16'h0, 0, 2'd0, 2'd0, 0, 1);
    step("R2 hold", 16'h1234, 16'h0, 16'hBEEF, 0, 2'd0, 2'd2, 0, 0);
    // R4 9-bit offsets at both extremes, R7 routing
    step("R4 neg", 16'hFF00, 16'hAAAA, 16'h0, 0, 2'd2, 2'd1, 0, 1);
    step("R4 pos", 16'hFEFF, 16'hAAAA, 16'h0, 0, 2'd2, 2'd1, 0, 1);
    step("R4 minus1", 16'h01FF, 16'h0, 16'h0, 0, 2'd2, 2'd1, 0, 0);
    // R5 6-bit offsets on base register, upper IR bits must be ignored
    step("R5 neg", 16'hFFE0, 16'h0010, 16'h0, 1, 2'd1, 2'd0, 0, 0);
    step("R5 pos", 16'h001F, 16'h4000, 16'h0, 1, 2'd1, 2'd1, 0, 0);
    // R10 wrap in both directions
    step("R10 up", 16'h001F, 16'hFFF0, 16'h0, 1, 2'd1, 2'd0, 0, 0);
    step("R10 down", 16'h0020, 16'h0005, 16'h0, 1, 2'd1, 2'd1, 0, 1);
    step("R10 pcinc", 16'h0000, 16'h0, 16'hFFFF, 0, 2'd0, 2'd2, 0, 1);
    step("R10 pcwrap", 16'h0000, 16'h0, 16'h0, 0, 2'd0, 2'd0, 0, 1);
    // R6 zero offset, both codes
    step("R6 none", 16'hFFFF, 16'h7777, 16'h0, 1, 2'd0, 2'd1, 0, 0);
    step("R6 rsvd", 16'hFFFF, 16'h7777, 16'h0, 0, 2'd3, 2'd1, 0, 0);
    // R8 bus jump and hold
    step("R8 bus", 16'h0000, 16'h0, 16'h8001, 0, 2'd0, 2'd2, 0, 1);
    step("R8 hold", 16'h0000, 16'h0, 16'h1111, 0, 2'd0, 2'd3, 0, 1);
    // R9 trap vector zero-extended, upper IR ignored
    step("R9 vec", 16'hFF25, 16'h0, 16'h0, 0, 2'd2, 2'd0, 1, 0);
    step("R9 vec lo", 16'h8080, 16'h0, 16'h0, 1, 2'd1, 2'd0, 1, 0);
    // random stretch covering all requirements, R2 load enable random
    for (int k = 0; k < 300; k++) begin
      step("R2-rand", 16'($urandom), 16'($urandom), 16'($urandom),
           1'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
    end
    @(negedge clk);
    check("R2 final pc", pc_o, 16'(pc_m));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule